// File: doc/BRIEF.md
# Deferred Floating-Point Exception Bounce Controller

This block sits on the instruction acceptance path of a floating-point coprocessor and reports possible exceptions one instruction late. For each issued arithmetic instruction it looks only at the operand exponents, before any result exists, and decides whether the operation could overflow, underflow or turn invalid. If so, the instruction is still accepted. The block also sets a sticky exceptional flag and keeps a copy of the instruction word in a capture register. For a short-vector operation, the register-number fields of that copy are moved to the iteration that was flagged.

While the flag is set, the next coprocessor instruction that is not exempt is refused (bounced). The main processor then takes an undefined-instruction trap, and its support code finds the offending instruction in the capture register. The bounced trigger instruction gets no processing and changes nothing; it is retried later. Register transfers that address the exception control register, the capture register or the ID register are always accepted, so the support code can inspect and clear the state. Software clears the flag by writing zero to the flag bit through a register-write port.

Top module: `deferExcBounce`

## Requirements
- R1: After reset, accept, bounce and excFlag are 0 and capWord is all zeros.
- R2: The cycle after a clock edge that samples issueValid high, exactly one of accept and bounce is 1. In a cycle that follows a sample with issueValid low, both are 0.
- R3: A multiply (issueWord[31:30]=01) is potentially exceptional when (expA-127)+(expB-127) >= 127 or <= -126, taking both exponents as unsigned 8-bit values.
- R4: An add/subtract (issueWord[31:30]=10) is potentially exceptional when either exponent equals 255. Other arithmetic (00) and register transfers (11) are never potentially exceptional.
- R5: An accepted, potentially exceptional instruction sets excFlag and loads capWord on the same edge. capWord is the issued word with its three 5-bit register fields [14:10], [9:5] and [4:0] each increased by iterIdx, modulo 32. All other bits are copied unchanged.
- R6: While excFlag is 1, a non-exempt instruction is bounced and leaves both excFlag and capWord unchanged.
- R7: A register transfer (kind 11) with target field issueWord[29:27] equal to 0, 1 or 2 is always accepted. One with target 3 to 7 is bounced while excFlag is 1.
- R8: regWrEn with ctrlWrFlag=0 clears excFlag and capWord on the next edge. regWrEn with ctrlWrFlag=1 changes nothing.
- R9: If a clearing write and an accepted, potentially exceptional instruction meet on the same edge, the new capture wins: excFlag is 1 and capWord holds the new word.
- R10: excFlag never clears by itself. A bounce does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | One-cycle instruction issue strobe |
| issueWord | input | 32 | Issued instruction word |
| expA | input | 8 | Biased exponent of first operand |
| expB | input | 8 | Biased exponent of second operand |
| iterIdx | input | 3 | Short-vector iteration index of this issue |
| regWrEn | input | 1 | Write strobe for the exception control register |
| ctrlWrFlag | input | 1 | Value written to the flag bit |
| accept | output | 1 | Instruction accepted (one cycle) |
| bounce | output | 1 | Instruction refused (one cycle) |
| excFlag | output | 1 | Sticky exceptional flag |
| capWord | output | 32 | Captured, iteration-adjusted instruction word |

## Verification
The hardest case to reach is a trigger arriving while the flag is set. It needs a flagged instruction first, and every exponent pair then has to start from a cleared state again. The bench sweeps each multiply and add exponent pair through a fixed cycle: issue, check the flag, send a harmless trigger that must bounce without side effects, then clear. Collisions of a clear write with a new capture, and register transfers to every target while the flag is set, are driven directly to reach the priority and exemption corners.

// File: rtl/deferExcPkg.sv
package deferExcPkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_MUL   = 2'b01,
    KIND_ADD   = 2'b10,
    KIND_XFER  = 2'b11
  } opKindT;

  typedef struct packed {
    logic capLoad;
    logic capClear;
  } pathStrobeT;
endpackage

// File: rtl/deferExcPath.sv
module deferExcPath
  import deferExcPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8,
  parameter int REG_W  = 5,
  parameter int NUM_FIELDS = 3,
  parameter int ITER_W = 3,
  parameter int TGT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] issueWord,
  input  logic [EXP_W-1:0]  expA,
  input  logic [EXP_W-1:0]  expB,
  input  logic [ITER_W-1:0] iterIdx,
  input  pathStrobeT        strobe,
  output opKindT            kind,
  output logic [TGT_W-1:0]  xferTarget,
  output logic              potExc,
  output logic [WORD_W-1:0] capWord
);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int SUM_W    = EXP_W + 2;
  localparam int OVF_SUM  = 3 * BIAS;   // unbiased sum >= BIAS
  localparam int UNF_SUM  = BIAS + 1;   // unbiased sum <= -(BIAS-1)
  localparam int FIELD_LO = REG_W * NUM_FIELDS;

  logic [SUM_W-1:0]  expSum;
  logic              mulRisk, addRisk;
  logic [WORD_W-1:0] adjWord;

  assign kind       = opKindT'(issueWord[WORD_W-1 -: 2]);
  assign xferTarget = issueWord[WORD_W-3 -: TGT_W];

  always_comb begin
    expSum  = SUM_W'(expA) + SUM_W'(expB);
    mulRisk = (expSum >= SUM_W'(OVF_SUM)) || (expSum <= SUM_W'(UNF_SUM));
    addRisk = (&expA) || (&expB);
    unique case (kind)
      KIND_MUL: potExc = mulRisk;
      KIND_ADD: potExc = addRisk;
      default:  potExc = 1'b0;
    endcase
  end

  // Re-point each register field to the flagged vector iteration
  assign adjWord[WORD_W-1:FIELD_LO] = issueWord[WORD_W-1:FIELD_LO];
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign adjWord[f*REG_W +: REG_W] =
      issueWord[f*REG_W +: REG_W] + REG_W'(iterIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  capWord <= '0;
    else if (strobe.capLoad)    capWord <= adjWord;
    else if (strobe.capClear)   capWord <= '0;
  end

  assert_cap_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capClear |=> (capWord == '0));
  assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capLoad && !strobe.capClear) |=> $stable(capWord));
endmodule

// File: rtl/deferExcCtrl.sv
module deferExcCtrl
  import deferExcPkg::*;
#(
  parameter int TGT_W      = 3,
  parameter int EXEMPT_MAX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  opKindT           kind,
  input  logic [TGT_W-1:0] xferTarget,
  input  logic             potExc,
  input  logic             regWrEn,
  input  logic             ctrlWrFlag,
  output pathStrobeT       strobe,
  output logic             accept,
  output logic             bounce,
  output logic             excFlag
);
  logic exempt, doBounce, doAccept, setNow, clearNow;

  always_comb begin
    exempt   = (kind == KIND_XFER) && (xferTarget <= TGT_W'(EXEMPT_MAX));
    doBounce = issueValid && excFlag && !exempt;
    doAccept = issueValid && !doBounce;
    setNow   = doAccept && potExc;
    clearNow = regWrEn && !ctrlWrFlag;
    strobe.capLoad  = setNow;
    strobe.capClear = clearNow && !setNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accept  <= 1'b0;
      bounce  <= 1'b0;
      excFlag <= 1'b0;
    end else begin
      accept <= doAccept;
      bounce <= doBounce;
      if (setNow)        excFlag <= 1'b1;
      else if (clearNow) excFlag <= 1'b0;
    end
  end

  assert_one_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> (accept ^ bounce));
  assert_no_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!accept && !bounce));
  assert_bounce_needs_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    bounce |-> $past(excFlag));
  assert_exempt_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && kind == KIND_XFER && xferTarget <= TGT_W'(EXEMPT_MAX)) |=> accept);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (excFlag && !(regWrEn && !ctrlWrFlag)) |=> excFlag);
  assert_first_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLoad |-> !excFlag);
endmodule

// File: rtl/deferExcBounce.sv
module deferExcBounce
  import deferExcPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8,
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [WORD_W-1:0] issueWord,
  input  logic [EXP_W-1:0]  expA,
  input  logic [EXP_W-1:0]  expB,
  input  logic [ITER_W-1:0] iterIdx,
  input  logic              regWrEn,
  input  logic              ctrlWrFlag,
  output logic              accept,
  output logic              bounce,
  output logic              excFlag,
  output logic [WORD_W-1:0] capWord
);
  localparam int TGT_W = 3;

  pathStrobeT       strobe;
  opKindT           kind;
  logic [TGT_W-1:0] xferTarget;
  logic             potExc;

  deferExcPath #(.WORD_W(WORD_W), .EXP_W(EXP_W), .ITER_W(ITER_W), .TGT_W(TGT_W)) uPath (
    .clk(clk), .rstN(rstN), .issueWord(issueWord), .expA(expA), .expB(expB),
    .iterIdx(iterIdx), .strobe(strobe), .kind(kind), .xferTarget(xferTarget),
    .potExc(potExc), .capWord(capWord)
  );

  deferExcCtrl #(.TGT_W(TGT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .kind(kind),
    .xferTarget(xferTarget), .potExc(potExc), .regWrEn(regWrEn),
    .ctrlWrFlag(ctrlWrFlag), .strobe(strobe), .accept(accept),
    .bounce(bounce), .excFlag(excFlag)
  );
endmodule

// File: tb/deferExcBounce_test.sv
module deferExcBounce_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] issueWord = '0;
  logic [7:0]  expA = '0, expB = '0;
  logic [2:0]  iterIdx = '0;
  logic        regWrEn = 1'b0, ctrlWrFlag = 1'b0;
  logic        accept, bounce, excFlag;
  logic [31:0] capWord;
  int testCnt = 0, failCnt = 0;

  deferExcBounce uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [1:0] k, input logic [2:0] t,
                                         input logic [4:0] d, n, m);
    return {k, t, 12'hA5C, d, n, m};
  endfunction

  function automatic logic [31:0] adjust(input logic [31:0] w, input logic [2:0] it);
    logic [4:0] d, n, m;
    d = w[14:10] + 5'(it); n = w[9:5] + 5'(it); m = w[4:0] + 5'(it);
    return {w[31:15], d, n, m};
  endfunction

  // drive at negedge, return at the following negedge (outputs settled)
  task automatic issue(input logic [31:0] w, input logic [7:0] a, b, input logic [2:0] it);
    issueValid = 1'b1; issueWord = w; expA = a; expB = b; iterIdx = it;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic writeFlag(input logic v);
    regWrEn = 1'b1; ctrlWrFlag = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sweepOne(input logic [1:0] k, input logic [7:0] a, b, input bit expFlag,
                          input string req);
    logic [31:0] w;
    w = mkWord(k, 3'd5, 5'(a), 5'(b), 5'd31);
    issue(w, a, b, 3'(a));
    check("R2", {bounce, accept}, 32'b01);
    check(req, excFlag, expFlag);
    if (expFlag) begin
      check("R5", capWord, adjust(w, 3'(a)));
      issue(mkWord(2'b00, 3'd0, 5'd1, 5'd2, 5'd3), 8'd127, 8'd127, 3'd0);
      check("R6", {bounce, accept}, 32'b10);
      check("R10", excFlag, 1'b1);
      check("R6", capWord, adjust(w, 3'(a)));
      writeFlag(1'b0);
      check("R8", {excFlag, accept, bounce}, 32'b0);
      check("R8", capWord, 32'h0);
    end else begin
      @(negedge clk);
      check("R2", {bounce, accept}, 32'b00);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] w1, w2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", {accept, bounce, excFlag}, 32'b0);
    check("R1", capWord, 32'h0);

    // R3: multiply, full expA range against a spread of expB
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17) begin
        int s;
        s = (a - 127) + (b - 127);
        sweepOne(2'b01, 8'(a), 8'(b), (s >= 127) || (s <= -126), "R3");
      end
    for (int a = 0; a < 256; a++) begin
      sweepOne(2'b01, 8'(a), 8'd128, ((a - 127) + 1 >= 127) || ((a - 127) + 1 <= -126), "R3");
    end

    // R4: add/sub flags on all-ones exponent; kind 00 never flags
    for (int a = 0; a < 256; a++) begin
      sweepOne(2'b10, 8'(a), 8'd100, a == 255, "R4");
      sweepOne(2'b10, 8'(a), 8'd255, 1'b1, "R4");
      sweepOne(2'b00, 8'(a), 8'd255, 1'b0, "R4");
    end

    // R5: iteration rewrite with wrap of every field
    for (int it = 0; it < 8; it++) begin
      w1 = mkWord(2'b10, 3'd6, 5'd30, 5'd29, 5'd31);
      issue(w1, 8'd255, 8'd3, 3'(it));
      check("R5", capWord, adjust(w1, 3'(it)));
      writeFlag(1'b0);
    end

    // R7: transfers to every target while flag set
    w1 = mkWord(2'b01, 3'd0, 5'd4, 5'd5, 5'd6);
    issue(w1, 8'd250, 8'd250, 3'd1);
    check("R5", excFlag, 1'b1);
    for (int t = 0; t < 8; t++) begin
      issue(mkWord(2'b11, 3'(t), 5'd0, 5'd0, 5'd0), 8'd255, 8'd255, 3'd0);
      check("R7", {bounce, accept}, (t <= 2) ? 32'b01 : 32'b10);
      check("R7", capWord, adjust(w1, 3'd1));
      check("R10", excFlag, 1'b1);
    end

    // R8: writing a 1 has no effect
    writeFlag(1'b1);
    check("R8", excFlag, 1'b1);
    check("R8", capWord, adjust(w1, 3'd1));
    writeFlag(1'b0);
    check("R8", excFlag, 1'b0);

    // R9: clear write and new capture on the same edge
    w2 = mkWord(2'b10, 3'd2, 5'd7, 5'd8, 5'd9);
    regWrEn = 1'b1; ctrlWrFlag = 1'b0;
    issue(w2, 8'd255, 8'd0, 3'd2);
    regWrEn = 1'b0;
    check("R9", excFlag, 1'b1);
    check("R9", capWord, adjust(w2, 3'd2));
    // clear while a trigger bounces on the same edge
    regWrEn = 1'b1;
    issue(mkWord(2'b01, 3'd0, 5'd1, 5'd1, 5'd1), 8'd255, 8'd255, 3'd0);
    regWrEn = 1'b0;
    check("R6", {bounce, accept}, 32'b10);
    check("R8", {excFlag}, 1'b0);
    check("R8", capWord, 32'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule